// File: doc/BRIEF.md
# Bidirectional Pin Bank with Standby Handling

This block is an eight-pin general-purpose input/output bank sitting on a simple single-cycle register bus. Software selects the direction of each pin through a direction register and the outgoing levels through a data register. The block drives an output-enable vector and an output-level vector toward external pad buffers, and it brings pad levels in through a two-flop synchronizer so that reads of the data address see a stable value.

A pin may instead take its level from an external timed-pulse source. The pulse bit is chosen in place of the data bit when the per-pin pulse enable is set, but the pin only leaves the pad when its direction bit is 1, because the output enable follows the direction register alone. Two low-power inputs are honoured. Hardware standby clears both registers just as reset does. Software standby freezes the port: both registers ignore writes, and every pin set as an output holds the level it had just before standby began.

Top module: `pinbank_port`

## Requirements
- R1: A register is selected by comparing only address bits [15:0]. The direction register sits at 0xFFD4 and the data register at 0xFFD6. Bits above bit 15 do not take part in the compare.
- R2: A read of the direction address returns 0xFF whatever the direction register holds.
- R3: After reset, padOe is 0x00, padOut is 0x00 and busRdata is 0x00.
- R4: While hwStandby is high at a clock edge, the direction and data registers clear to 0x00, and any write in that cycle is ignored.
- R5: padOe equals the direction register, so bit i is 1 exactly when pin i is an output.
- R6: A read of the data address returns, for each bit i, the data register bit when direction bit i is 1, and the synchronized pad level when it is 0.
- R7: Pad levels pass through two flops. A read strobe issued in the same cycle as a pad change, or in the cycle after it, returns the old level. A read strobe issued two cycles after the change returns the new level.
- R8: When software standby is not active, padOut bit i is pulseVal[i] when pulseEn[i] is 1 and data register bit i otherwise.
- R9: While swStandby is high, writes to either register are ignored.
- R10: While swStandby is high, padOut and padOe keep the values they had in the cycle before standby began, even if pulseEn or pulseVal change.
- R11: busRdata becomes valid at the clock edge that samples busRd. After any edge at which busRd is low, busRdata is 0x00.
- R12: A write or read to any address other than the two register addresses changes nothing, and a read of such an address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hwStandby | input | 1 | Hardware standby, clears the port |
| swStandby | input | 1 | Software standby, freezes the port |
| busAddr | input | 24 | Bus address; only bits [15:0] are decoded |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, registered |
| padIn | input | 8 | Pad input levels, asynchronous |
| pulseEn | input | 8 | Per-pin select of the pulse-output source |
| pulseVal | input | 8 | Pulse-output levels |
| padOe | output | 8 | Pad output enables |
| padOut | output | 8 | Pad output levels |

## Verification
The hardest condition to reach from the ports is software standby in which the live output level differs from the held one. The direction must be set, a data level must be latched, and then a data write and a change of the pulse source must be attempted while swStandby is high. The bench changes data, pulseEn and pulseVal inside the standby window, and it checks that padOut and a read-back of the data register still show the values from before standby. It also checks that the live pulse value appears on padOut as soon as standby is released.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic dirWe;   // load the direction register
    logic dataWe;  // load the data register
    logic rdDir;   // read of the direction address
    logic rdData;  // read of the data address
    logic freeze;  // software standby: hold the outputs
    logic clear;   // hardware standby: clear the registers
  } pinStrobe_t;

endpackage

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DEC_W = 16,
  parameter logic [DEC_W-1:0] DIR_OFFSET = 16'hFFD4,
  parameter logic [DEC_W-1:0] DATA_OFFSET = 16'hFFD6
) (
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output pinStrobe_t        strobe
);

  logic [DEC_W-1:0] lowAddr;
  logic hitDir;
  logic hitData;
  logic wrAllowed;

  assign lowAddr = busAddr[DEC_W-1:0];

  always_comb begin
    hitDir = (lowAddr == DIR_OFFSET);
    hitData = (lowAddr == DATA_OFFSET);
    wrAllowed = busWr && !swStandby && !hwStandby;
    strobe.dirWe = wrAllowed && hitDir;
    strobe.dataWe = wrAllowed && hitData;
    strobe.rdDir = busRd && hitDir;
    strobe.rdData = busRd && hitData;
    strobe.freeze = swStandby && !hwStandby;
    strobe.clear = hwStandby;
  end

endmodule

// File: rtl/pinbank_dpath.sv
module pinbank_dpath
  import pinbank_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  pinStrobe_t       strobe,
  input  logic [WIDTH-1:0] busWdata,
  input  logic [WIDTH-1:0] padIn,
  input  logic [WIDTH-1:0] pulseEn,
  input  logic [WIDTH-1:0] pulseVal,
  output logic [WIDTH-1:0] busRdata,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padOut
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] dataReg;
  logic [WIDTH-1:0] heldOut;
  logic [WIDTH-1:0] liveOut;
  logic [WIDTH-1:0] pinView;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];

  // Input synchronizer chain.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= padIn;
  end

  for (genvar k = 1; k < SYNC_STAGES; k++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[k] <= '0;
      else       syncQ[k] <= syncQ[k-1];
    end
  end

  // Direction and data registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= '0;
      dataReg <= '0;
    end else if (strobe.clear) begin
      dirReg <= '0;
      dataReg <= '0;
    end else begin
      if (strobe.dirWe)  dirReg <= busWdata;
      if (strobe.dataWe) dataReg <= busWdata;
    end
  end

  // Per-pin source selection.
  for (genvar i = 0; i < WIDTH; i++) begin : gPin
    assign liveOut[i] = pulseEn[i] ? pulseVal[i] : dataReg[i];
    assign pinView[i] = dirReg[i] ? dataReg[i] : syncQ[SYNC_STAGES-1][i];
  end

  // Output hold register used across software standby.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              heldOut <= '0;
    else if (!strobe.freeze) heldOut <= liveOut;
  end

  assign padOut = strobe.freeze ? heldOut : liveOut;
  assign padOe = dirReg;

  // Registered read data.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              busRdata <= '0;
    else if (strobe.rdDir)  busRdata <= ALL_ONES;
    else if (strobe.rdData) busRdata <= pinView;
    else                    busRdata <= '0;
  end

endmodule

// File: rtl/pinbank_port.sv
module pinbank_port
  import pinbank_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int ADDR_W = 24,
  parameter int SYNC_STAGES = 2,
  parameter logic [15:0] DIR_OFFSET = 16'hFFD4,
  parameter logic [15:0] DATA_OFFSET = 16'hFFD6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  input  logic [WIDTH-1:0]  padIn,
  input  logic [WIDTH-1:0]  pulseEn,
  input  logic [WIDTH-1:0]  pulseVal,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padOut
);

  pinStrobe_t strobe;

  pinbank_ctrl #(
    .ADDR_W(ADDR_W),
    .DEC_W(16),
    .DIR_OFFSET(DIR_OFFSET),
    .DATA_OFFSET(DATA_OFFSET)
  ) uCtrl (
    .hwStandby(hwStandby),
    .swStandby(swStandby),
    .busAddr(busAddr),
    .busWr(busWr),
    .busRd(busRd),
    .strobe(strobe)
  );

  pinbank_dpath #(
    .WIDTH(WIDTH),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDpath (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .busWdata(busWdata),
    .padIn(padIn),
    .pulseEn(pulseEn),
    .pulseVal(pulseVal),
    .busRdata(busRdata),
    .padOe(padOe),
    .padOut(padOut)
  );

endmodule

// File: rtl/pinbank_port_chk.sv
module pinbank_port_chk #(
  parameter int WIDTH = 8,
  parameter int ADDR_W = 24,
  parameter logic [15:0] DIR_OFFSET = 16'hFFD4
) (
  input logic              clk,
  input logic              rstN,
  input logic              hwStandby,
  input logic              swStandby,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic [WIDTH-1:0]  busRdata,
  input logic [WIDTH-1:0]  padOe,
  input logic [WIDTH-1:0]  padOut
);

  AST_HWSTBY_CLEARS_OE: assert property (@(posedge clk) disable iff (!rstN)
    hwStandby |=> (padOe == '0)); // R4

  AST_DIR_READS_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[15:0] == DIR_OFFSET) |=> (busRdata == '1)); // R2

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> (busRdata == '0)); // R11

  AST_SWSTBY_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (swStandby && !hwStandby) |=> $stable(padOe)); // R9

  AST_SWSTBY_HOLD_OUT: assert property (@(posedge clk) disable iff (!rstN || hwStandby)
    (swStandby && $past(swStandby) && !$past(hwStandby)) |-> $stable(padOut)); // R10

endmodule

bind pinbank_port pinbank_port_chk #(
  .WIDTH(WIDTH),
  .ADDR_W(ADDR_W),
  .DIR_OFFSET(DIR_OFFSET)
) uChk (
  .clk(clk),
  .rstN(rstN),
  .hwStandby(hwStandby),
  .swStandby(swStandby),
  .busAddr(busAddr),
  .busRd(busRd),
  .busRdata(busRdata),
  .padOe(padOe),
  .padOut(padOut)
);

// File: tb/sim_pinbank_port.sv
`timescale 1ns/1ps
module sim_pinbank_port;

  localparam logic [23:0] A_DIR = 24'h00FFD4;
  localparam logic [23:0] A_DATA = 24'h00FFD6;

  logic clk = 0;
  logic rstN = 0;
  logic hwStandby = 0;
  logic swStandby = 0;
  logic [23:0] busAddr = '0;
  logic busWr = 0;
  logic busRd = 0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] padIn = '0;
  logic [7:0] pulseEn = '0;
  logic [7:0] pulseVal = '0;
  logic [7:0] padOe;
  logic [7:0] padOut;

  int checks = 0;
  int fails = 0;
  logic [7:0] rd;

  always #4 clk = ~clk;

  pinbank_port u0 (
    .clk(clk), .rstN(rstN), .hwStandby(hwStandby), .swStandby(swStandby),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .busWdata(busWdata),
    .busRdata(busRdata), .padIn(padIn), .pulseEn(pulseEn), .pulseVal(pulseVal),
    .padOe(padOe), .padOut(padOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1;
    @(negedge clk);
    busWr = 0;
  endtask

  task automatic rdReg(input logic [23:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1;
    @(negedge clk);
    busRd = 0;
    d = busRdata;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=00 expected=01");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R3 oe", padOe, 8'h00);
    chk("R3 out", padOut, 8'h00);
    chk("R3 rdata", busRdata, 8'h00);
    rstN = 1;
    @(negedge clk);

    // Sweep of the direction register: padOe follows, read-back is all ones.
    for (int v = 0; v < 256; v++) begin
      wr(A_DIR, v[7:0]);
      chk("R5 oe", padOe, v[7:0]);
      rdReg(A_DIR, rd);
      chk("R2 dir read", rd, 8'hFF);
      @(negedge clk);
      chk("R11 idle rdata", busRdata, 8'h00);
    end

    // Sweep of the data-read mixing against a fixed pad pattern.
    padIn = 8'h3C;
    repeat (3) @(negedge clk);
    for (int v = 0; v < 256; v += 17) begin
      wr(A_DIR, v[7:0]);
      wr(A_DATA, ~v[7:0] ^ 8'h55);
      rdReg(A_DATA, rd);
      chk("R6 data read", rd, (v[7:0] & (~v[7:0] ^ 8'h55)) | (~v[7:0] & 8'h3C));
    end

    // Pulse source selection, per-pin.
    wr(A_DATA, 8'hA5);
    pulseVal = 8'h0F;
    for (int e = 0; e < 256; e += 51) begin
      pulseEn = e[7:0];
      #1;
      chk("R8 out mux", padOut, (e[7:0] & 8'h0F) | (~e[7:0] & 8'hA5));
    end
    pulseEn = 8'h00;

    // Address aliasing and unmatched addresses.
    wr(24'h5AFFD4, 8'h81);
    chk("R1 upper bits ignored", padOe, 8'h81);
    wr(24'h00FFD5, 8'h7E);
    chk("R12 other addr write", padOe, 8'h81);
    wr(24'h00FFD7, 8'h7E);
    rdReg(A_DATA, rd);
    chk("R12 data untouched", rd & 8'h81, 8'h81 & 8'hA5);
    rdReg(24'h00FFD8, rd);
    chk("R12 other addr read", rd, 8'h00);

    // Synchronizer latency on an input pin.
    wr(A_DIR, 8'h00);
    padIn = 8'h00;
    repeat (3) @(negedge clk);
    padIn = 8'hC3; busAddr = A_DATA; busRd = 1;
    @(negedge clk);
    chk("R7 one edge", busRdata, 8'h00);
    @(negedge clk);
    chk("R7 two edges", busRdata, 8'h00);
    @(negedge clk);
    chk("R7 three edges", busRdata, 8'hC3);
    busRd = 0;

    // Software standby freeze.
    wr(A_DIR, 8'hFF);
    wr(A_DATA, 8'hA5);
    @(negedge clk);
    swStandby = 1;
    wr(A_DATA, 8'h5A);
    wr(A_DIR, 8'h00);
    pulseEn = 8'hFF; pulseVal = 8'h0F;
    @(negedge clk);
    chk("R10 out held", padOut, 8'hA5);
    chk("R10 oe held", padOe, 8'hFF);
    rdReg(A_DATA, rd);
    chk("R9 data write blocked", rd, 8'hA5);
    swStandby = 0;
    #1;
    chk("R8 pulse after standby", padOut, 8'h0F);
    pulseEn = 8'h00;
    #1;
    chk("R8 data after standby", padOut, 8'hA5);

    // Hardware standby clear; a write in that window is ignored.
    @(negedge clk);
    hwStandby = 1; busAddr = A_DATA; busWdata = 8'hEE; busWr = 1;
    @(negedge clk);
    busWr = 0;
    chk("R4 oe cleared", padOe, 8'h00);
    hwStandby = 0;
    wr(A_DIR, 8'hFF);
    chk("R4 data cleared", padOut, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule